// File: doc/BRIEF.md
# Command-Port Watchdog Timer

This block is a watchdog timer that a host programs through a two-byte I/O window. The byte at offset 0 is a data port and the byte at offset 1 is a command port. Each byte written to the command port is decoded as a command. These commands arm, disarm or kick the watchdog. A probe command makes the next data-port read return a fixed identity byte. A further command starts an indirect register write: the next two data-port bytes give the register index and then the value to store there. The block keeps all of this sequencing state for as long as the host takes between accesses.

Once armed, the block counts two stages in 100 ms ticks, which a prescaler derives from the system clock. The first stage is an optional enable delay and the second is the reset delay. When the reset delay runs out, the block drives a reset pulse of a fixed length and returns to the stopped state. The host keeps the system alive by kicking the timer, and each kick restarts the reset-delay stage.

Top module: `portwdt_top`

## Requirements
- R1: `bus_addr`=1 selects the command port and `bus_addr`=0 selects the data port. A data-port write is ignored unless an indirect-write sequence is waiting for a byte.
- R2: Writing 0x30 to the command port arms a probe, so the next data-port read returns 0x95 and clears the probe. A data-port read that does not follow a probe returns 0x00, and `bus_rdata` is 0x00 whenever no data-port read is presented.
- R3: Writing 0x89 to the command port starts an indirect write: the next data-port byte is an index and the one after it is a value. Index 0x58 stores the high byte of the enable delay and 0x59 stores its low byte. Index 0x5E stores the high byte of the reset delay and 0x5F stores its low byte.
- R4: A command-port write before the value byte abandons the indirect write, so the byte that follows is ignored. A value byte sent to any index other than the four in R3 changes nothing.
- R5: After reset the watchdog is stopped, both delays are 0 and `wdt_rst` is low.
- R6: Writing 0x28 arms the watchdog, or re-arms it from the start if it is already running. The enable stage lasts M ticks, and M=0 skips it. The reset stage then lasts max(N,1) ticks. `wdt_rst` rises exactly (M+max(N,1))×TICK_CYCLES clock edges after the edge on which the arm command was written.
- R7: Writing 0x2A while the watchdog is armed, in either stage, restarts the reset stage, and `wdt_rst` rises max(N,1)×TICK_CYCLES edges after the kick. A kick while the watchdog is stopped does nothing.
- R8: Writing 0x29 stops the watchdog, and no reset follows.
- R9: On expiry `wdt_rst` is high for exactly PULSE_CYCLES clock cycles. The watchdog is then stopped and does not fire again without a new arm command.
- R10: Both delays are full 16-bit values, which covers 60000 ticks, and both the high and low bytes take part in the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host byte write strobe, one cycle per access |
| bus_rd | input | 1 | Host byte read strobe, one cycle per access |
| bus_addr | input | 1 | Port select: 1 = command, 0 = data |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle `bus_rd` is high |
| wdt_rst | output | 1 | Reset pulse on watchdog expiry |

## Verification
The bench measures the cycle on which the reset output rises for delay pairs that include zero stages and both register bytes. A design that mishandles a zero delay, ignores a high byte or clears its prescaler at the wrong moment lands a whole tick early or late. Kicks are applied in both stages, and a design that restarted from the enable stage or failed to clear its prescaler would fire at the wrong time. An indirect write broken off by a command, a value sent to an unknown index, and a kick while stopped are each followed by a timing measurement or a quiet window; a decoder that leaks these bytes into a register, or a kick that re-arms, changes that timing or produces a stray pulse. The bench reads the probe identity twice to catch a design that never clears its probe, and it measures the pulse width to catch an off-by-one pulse counter.

// File: rtl/portwdt_pkg.sv
package portwdt_pkg;

    localparam int DLY_W = 16;

    localparam logic [7:0] CMD_PROBE    = 8'h30;
    localparam logic [7:0] CMD_INDIRECT = 8'h89;
    localparam logic [7:0] CMD_ARM      = 8'h28;
    localparam logic [7:0] CMD_DISARM   = 8'h29;
    localparam logic [7:0] CMD_KICK     = 8'h2A;

    localparam logic [7:0] IDX_EN_HI  = 8'h58;
    localparam logic [7:0] IDX_EN_LO  = 8'h59;
    localparam logic [7:0] IDX_RST_HI = 8'h5E;
    localparam logic [7:0] IDX_RST_LO = 8'h5F;

    localparam logic [7:0] IDENT_BYTE = 8'h95;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ENABLE = 2'd1,
        PH_RESET  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_INDEX = 2'd1,
        SEQ_VALUE = 2'd2
    } seq_e;

    typedef struct packed {
        logic arm;
        logic disarm;
        logic kick;
    } ctl_s;

    typedef struct packed {
        logic [DLY_W-1:0] en_dly;
        logic [DLY_W-1:0] rst_dly;
    } delays_s;

    function automatic logic [DLY_W-1:0] put_byte(input logic [DLY_W-1:0] old,
                                                  input logic hi,
                                                  input logic [7:0] b);
        return hi ? {b, old[7:0]} : {old[DLY_W-1:8], b};
    endfunction

endpackage

// File: rtl/portwdt_hostif.sv
module portwdt_hostif
    import portwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output delays_s    dly,
    output ctl_s       ctl
);
    seq_e       seq_q;
    logic [7:0] idx_q;
    logic       probe_q;
    delays_s    dly_q;

    logic cmd_wr, dat_wr, dat_rd;
    assign cmd_wr = bus_wr &  bus_addr;
    assign dat_wr = bus_wr & ~bus_addr;
    assign dat_rd = bus_rd & ~bus_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= SEQ_IDLE;
            idx_q   <= 8'h00;
            probe_q <= 1'b0;
            dly_q   <= '0;
        end else begin
            if (dat_rd) probe_q <= 1'b0;
            if (cmd_wr) begin
                seq_q   <= (bus_wdata == CMD_INDIRECT) ? SEQ_INDEX : SEQ_IDLE;
                probe_q <= (bus_wdata == CMD_PROBE);
            end else if (dat_wr) begin
                unique case (seq_q)
                    SEQ_INDEX: begin
                        idx_q <= bus_wdata;
                        seq_q <= SEQ_VALUE;
                    end
                    SEQ_VALUE: begin
                        seq_q <= SEQ_IDLE;
                        unique case (idx_q)
                            IDX_EN_HI:  dly_q.en_dly  <= put_byte(dly_q.en_dly,  1'b1, bus_wdata);
                            IDX_EN_LO:  dly_q.en_dly  <= put_byte(dly_q.en_dly,  1'b0, bus_wdata);
                            IDX_RST_HI: dly_q.rst_dly <= put_byte(dly_q.rst_dly, 1'b1, bus_wdata);
                            IDX_RST_LO: dly_q.rst_dly <= put_byte(dly_q.rst_dly, 1'b0, bus_wdata);
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata  = (dat_rd && probe_q) ? IDENT_BYTE : 8'h00;
    assign dly        = dly_q;
    assign ctl.arm    = cmd_wr && (bus_wdata == CMD_ARM);
    assign ctl.disarm = cmd_wr && (bus_wdata == CMD_DISARM);
    assign ctl.kick   = cmd_wr && (bus_wdata == CMD_KICK);

endmodule

// File: rtl/portwdt_ticker.sv
module portwdt_ticker #(
    parameter int TICK_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !run)  pcnt_q <= '0;
        else if (pcnt_q == LAST) pcnt_q <= '0;
        else                     pcnt_q <= pcnt_q + 1'b1;
    end

    assign tick = run && (pcnt_q == LAST);

endmodule

// File: rtl/portwdt_core.sv
module portwdt_core
    import portwdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  ctl_s    ctl,
    input  delays_s dly,
    input  logic    tick,
    output logic    tick_clr,
    output phase_e  phase,
    output logic    wdt_rst
);
    localparam int PCW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PCW-1:0] PULSE_LOAD = PCW'(PULSE_CYCLES);

    phase_e           phase_q;
    logic [DLY_W-1:0] cnt_q;
    logic [PCW-1:0]   pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pulse_q <= '0;
        end else begin
            if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
            if (ctl.disarm) begin
                phase_q <= PH_IDLE;
            end else if (ctl.arm) begin
                if (dly.en_dly == '0) begin
                    phase_q <= PH_RESET;
                    cnt_q   <= dly.rst_dly;
                end else begin
                    phase_q <= PH_ENABLE;
                    cnt_q   <= dly.en_dly;
                end
            end else if (ctl.kick && phase_q != PH_IDLE) begin
                phase_q <= PH_RESET;
                cnt_q   <= dly.rst_dly;
            end else if (tick) begin
                unique case (phase_q)
                    PH_ENABLE: begin
                        if (cnt_q <= 1) begin
                            phase_q <= PH_RESET;
                            cnt_q   <= dly.rst_dly;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_RESET: begin
                        if (cnt_q <= 1) begin
                            phase_q <= PH_IDLE;
                            pulse_q <= PULSE_LOAD;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign tick_clr = ctl.arm || (ctl.kick && phase_q != PH_IDLE);
    assign phase    = phase_q;
    assign wdt_rst  = (pulse_q != '0);

endmodule

// File: rtl/portwdt_top.sv
module portwdt_top
    import portwdt_pkg::*;
#(
    parameter int TICK_CYCLES  = 25_000_000,
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst
);
    delays_s dly_w;
    ctl_s    ctl_w;
    phase_e  phase_w;
    logic    tick_w;
    logic    tick_clr_w;

    portwdt_hostif u_hostif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dly       (dly_w),
        .ctl       (ctl_w)
    );

    portwdt_ticker #(.TICK_CYCLES(TICK_CYCLES)) u_ticker (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr_w),
        .run  (phase_w != PH_IDLE),
        .tick (tick_w)
    );

    portwdt_core #(.PULSE_CYCLES(PULSE_CYCLES)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl_w),
        .dly      (dly_w),
        .tick     (tick_w),
        .tick_clr (tick_clr_w),
        .phase    (phase_w),
        .wdt_rst  (wdt_rst)
    );

endmodule

// File: rtl/portwdt_chk.sv
module portwdt_chk
    import portwdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       wdt_rst,
    input logic [1:0] phase
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= 0;
        else if (wdt_rst) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && !bus_addr) |-> bus_rdata == 8'h00);

    assert_rdata_values_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr) |-> (bus_rdata == 8'h00 || bus_rdata == IDENT_BYTE));

    assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wdt_rst);

    assert_kick_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && bus_wdata == CMD_KICK && phase == PH_IDLE) |=> phase == PH_IDLE);

    assert_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && bus_wdata == CMD_DISARM) |=> phase == PH_IDLE);

    assert_expire_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst) |-> phase == PH_IDLE);

    assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
        run_q <= PULSE_CYCLES);

endmodule

bind portwdt_top portwdt_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_rst   (wdt_rst),
    .phase     (phase_w)
);

// File: tb/sim_portwdt_top.sv
module sim_portwdt_top;
    localparam int T = 4;
    localparam int P = 3;
    localparam int LIMIT = 3000;
    localparam int NVEC = 8;

    // {enable delay, reset delay, expected latency = (M + max(N,1)) * T}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd0,   16'd3,   16'd12},
        {16'd2,   16'd3,   16'd20},
        {16'd0,   16'd1,   16'd4},
        {16'd0,   16'd0,   16'd4},
        {16'd1,   16'd1,   16'd8},
        {16'd3,   16'd0,   16'd16},
        {16'd0,   16'd256, 16'd1024},
        {16'd258, 16'd1,   16'd1036}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    portwdt_top #(.TICK_CYCLES(T), .PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic prog(input logic [7:0] idx, input logic [7:0] val);
        wr(1'b1, 8'h89);
        wr(1'b0, idx);
        wr(1'b0, val);
    endtask

    task automatic set_delays(input logic [15:0] en, input logic [15:0] rd_l);
        prog(8'h58, en[15:8]);
        prog(8'h59, en[7:0]);
        prog(8'h5E, rd_l[15:8]);
        prog(8'h5F, rd_l[7:0]);
    endtask

    task automatic measure(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!wdt_rst && lat < LIMIT);
    endtask

    task automatic width(output int w);
        w = 0;
        while (wdt_rst && w < LIMIT) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst) hits++;
        end
    endtask

    initial begin
        #400_000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int lat, w, hits;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5: reset state
        check(wdt_rst == 1'b0, "R5 out low after reset", wdt_rst, 0);
        rd(1'b0, v);
        check(v == 8'h00, "R2 read without probe", v, 0);
        wr(1'b1, 8'h28);
        measure(lat);
        check(lat == T, "R5 cleared delays expire in one tick", lat, T);
        width(w);

        // R2: probe handshake
        wr(1'b1, 8'h30);
        rd(1'b0, v);
        check(v == 8'h95, "R2 probe identity", v, 8'h95);
        rd(1'b0, v);
        check(v == 8'h00, "R2 probe consumed", v, 0);
        wr(1'b1, 8'h30);
        rd(1'b1, v);
        check(v == 8'h00, "R2 command port read", v, 0);

        // R3 R6 R10: vector table
        for (int i = 0; i < NVEC; i++) begin
            set_delays(VEC[i][47:32], VEC[i][31:16]);
            wr(1'b1, 8'h28);
            measure(lat);
            check(lat == int'(VEC[i][15:0]), "R6 arm-to-reset latency", lat, int'(VEC[i][15:0]));
            width(w);
            check(w == P, "R9 pulse width", w, P);
        end

        // R9: stopped after expiry
        quiet(60, hits);
        check(hits == 0, "R9 no refire after expiry", hits, 0);

        // R7: kick in reset stage
        set_delays(16'd0, 16'd5);
        wr(1'b1, 8'h28);
        repeat (8) @(negedge clk);
        wr(1'b1, 8'h2A);
        measure(lat);
        check(lat == 5 * T, "R7 kick in reset stage", lat, 5 * T);
        width(w);

        // R7: kick in enable stage
        set_delays(16'd5, 16'd2);
        wr(1'b1, 8'h28);
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h2A);
        measure(lat);
        check(lat == 2 * T, "R7 kick in enable stage", lat, 2 * T);
        width(w);

        // R7: kick while stopped
        wr(1'b1, 8'h2A);
        quiet(60, hits);
        check(hits == 0, "R7 kick while stopped ignored", hits, 0);

        // R8: disarm
        set_delays(16'd0, 16'd3);
        wr(1'b1, 8'h28);
        repeat (2) @(negedge clk);
        wr(1'b1, 8'h29);
        quiet(60, hits);
        check(hits == 0, "R8 disarm prevents reset", hits, 0);

        // R4 R1: abandoned sequence and stray data byte
        wr(1'b1, 8'h89);
        wr(1'b0, 8'h5F);
        wr(1'b1, 8'h29);
        wr(1'b0, 8'h09);
        wr(1'b0, 8'h5F);
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h28);
        measure(lat);
        check(lat == 3 * T, "R4 R1 abandoned write ignored", lat, 3 * T);
        width(w);

        // R4: unknown index
        prog(8'h40, 8'h07);
        prog(8'h5D, 8'h02);
        wr(1'b1, 8'h28);
        measure(lat);
        check(lat == 3 * T, "R4 unknown index ignored", lat, 3 * T);
        width(w);

        // R6: re-arm while running restarts enable stage
        set_delays(16'd2, 16'd2);
        wr(1'b1, 8'h28);
        repeat (5) @(negedge clk);
        wr(1'b1, 8'h28);
        measure(lat);
        check(lat == 4 * T, "R6 re-arm restarts", lat, 4 * T);
        width(w);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule